// File: doc/BRIEF.md
# Per-Queue Batch Write-Back Scheduler

This block sits on the write side of a hybrid packet buffer. Fixed-size cells arrive one per cycle, each tagged with a queue number. They are held in a small on-chip cache that is organised as a set of logical FIFOs, one per queue. A count of held cells is kept for each FIFO.

Whenever the output is free, the block looks for a FIFO that holds at least a full batch of cells. It searches in round-robin order. It removes exactly one batch from the chosen FIFO and presents it as a single wide word, ready for a parallel write into slow bulk memory. A FIFO with fewer than a full batch is never serviced.

The cache is built as one simple dual-port bank per batch lane, so it maps onto block RAM. A cell that would push the cache past its total capacity, or past its own FIFO's depth, is discarded and flagged.

Top module: `qwb_batch_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` and `ovf` are 0 and every FIFO is empty.
- R2: A granted FIFO's count falls by BATCH on the granting edge. An accepted arrival to the same FIFO on that edge adds one, giving a net change of 1-BATCH. Cells that remain are served in later batches.
- R3: A FIFO holding fewer than BATCH cells is never granted, and `out_valid` never rises while no FIFO holds BATCH cells.
- R4: When the output register is empty or is being accepted (`out_ready` high), and some FIFO holds at least BATCH cells before a rising edge, that edge grants a batch. `out_valid` is high in the following cycle.
- R5: The round-robin search starts at the queue one past the last granted queue, wrapping from NUM_Q-1 to 0, and starts at queue 0 after reset. If nothing is granted, the start point does not move.
- R6: Within a queue, cells leave in arrival order. Lane k of `out_data` (bits k*CELL_W upward) carries the k-th oldest cell of the batch, with lane 0 the oldest.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `out_qid` and `out_data` unchanged, and no new grant is made.
- R8: The total cell count never exceeds CAPACITY. An arriving cell is discarded when the total before the edge equals CAPACITY. `ovf` is high for exactly the cycle after each discarded cell.
- R9: An arriving cell is discarded, with the same `ovf` pulse, when its FIFO already holds QDEPTH cells. No FIFO ever holds more than QDEPTH cells.
- R10: At most one batch is granted per edge. With `out_ready` held high, batches can issue on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An arriving cell is present this cycle |
| in_qid | input | $clog2(NUM_Q) | Queue number of the arriving cell |
| in_data | input | CELL_W | Arriving cell payload |
| out_ready | input | 1 | The bulk-memory side accepts the batch on the output |
| out_valid | output | 1 | A batch is presented |
| out_qid | output | $clog2(NUM_Q) | Queue the presented batch came from |
| out_data | output | BATCH*CELL_W | Batch cells, oldest in lane 0 |
| ovf | output | 1 | A cell was discarded on the previous edge |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it:
- A batch shows on the output in the cycle after the edge that granted it.
- The `ovf` pulse follows the discarded cell by one cycle.
- A stalled batch must be unchanged one cycle after a cycle in which `out_ready` was low.

The bench drives its inputs at the falling edge. A behavioural model, built from per-queue queues and integer counts, advances at the rising edge. All outputs are compared with the model at the next falling edge, so each expected value is sampled exactly one edge after its cause. Directed phases cover these cases:
- a lone batch;
- round-robin rotation with stalls;
- arrivals to a queue in the same cycle it is granted;
- total-capacity drops and per-queue depth drops.

A long random phase then mixes arrivals and back-pressure.

// File: rtl/qwb_pkg.sv
package qwb_pkg;

  // index arithmetic modulo a count, used for the round-robin search and pointer
  function automatic int wrap_add(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/qwb_bank.sv
// One lane of the cell cache: simple dual-port RAM with a registered read port.
module qwb_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/qwb_rr_arb.sv
// Round-robin pick among eligible queues, search starting at ptr.
module qwb_rr_arb #(
  parameter int N   = 4,
  localparam int QW = $clog2(N)
) (
  input  logic [N-1:0]  elig,
  input  logic [QW-1:0] ptr,
  output logic          any,
  output logic [QW-1:0] sel
);

  // walk from the farthest offset down to zero so the nearest eligible queue wins
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      int idx;
      idx = qwb_pkg::wrap_add(int'(ptr), i, N);
      if (elig[idx]) begin
        any = 1'b1;
        sel = QW'(idx);
      end
    end
  end

endmodule

// File: rtl/qwb_occupancy.sv
// Per-queue counts, write/read positions and the total cell count.
module qwb_occupancy #(
  parameter int NUM_Q    = 4,
  parameter int BATCH    = 4,
  parameter int QDEPTH   = 8,
  parameter int CAPACITY = 20,
  localparam int QW = $clog2(NUM_Q),
  localparam int BL = $clog2(BATCH),
  localparam int QL = $clog2(QDEPTH),
  localparam int RW = QL - BL,
  localparam int CW = $clog2(QDEPTH + 1),
  localparam int TW = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [QW-1:0]    in_qid,
  input  logic             grant,
  input  logic [QW-1:0]    grant_q,
  output logic             accept,
  output logic             drop,
  output logic [BL-1:0]    wr_bank,
  output logic [RW-1:0]    wr_row,
  output logic [RW-1:0]    rd_row,
  output logic [NUM_Q-1:0] elig
);

  logic [CW-1:0] cnt  [NUM_Q];
  logic [QL-1:0] widx [NUM_Q];
  logic [RW-1:0] rrow [NUM_Q];
  logic [TW-1:0] total;

  logic full_tot, full_q;

  always_comb begin
    full_tot = total >= TW'(CAPACITY);
    full_q   = cnt[in_qid] >= CW'(QDEPTH);
    accept   = in_valid && !full_tot && !full_q;
    drop     = in_valid && !accept;
    wr_bank  = widx[in_qid][BL-1:0];
    wr_row   = widx[in_qid][QL-1:BL];
    rd_row   = rrow[grant_q];
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic hit_in, hit_out;
    assign hit_in  = accept && (in_qid == QW'(g));
    assign hit_out = grant && (grant_q == QW'(g));
    assign elig[g] = cnt[g] >= CW'(BATCH);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[g]  <= '0;
        widx[g] <= '0;
        rrow[g] <= '0;
      end else begin
        cnt[g] <= cnt[g] + CW'(hit_in) - (hit_out ? CW'(BATCH) : CW'(0));
        if (hit_in)  widx[g] <= widx[g] + QL'(1);
        if (hit_out) rrow[g] <= rrow[g] + RW'(1);
      end
    end

    assert_depth_bound_R9: assert property (@(posedge clk) disable iff (rst)
      cnt[g] <= CW'(QDEPTH));
  end

  always_ff @(posedge clk) begin
    if (rst) total <= '0;
    else     total <= total + TW'(accept) - (grant ? TW'(BATCH) : TW'(0));
  end

  assert_total_cap_R8: assert property (@(posedge clk) disable iff (rst)
    total <= TW'(CAPACITY));

  assert_grant_eligible_R3: assert property (@(posedge clk) disable iff (rst)
    grant |-> cnt[grant_q] >= CW'(BATCH));

endmodule

// File: rtl/qwb_batch_sched.sv
// Tail-side batch write-back scheduler. NUM_Q, BATCH and QDEPTH are powers of two,
// BATCH >= 2 and QDEPTH >= 2*BATCH.
module qwb_batch_sched #(
  parameter int NUM_Q    = 4,
  parameter int BATCH    = 4,
  parameter int QDEPTH   = 8,
  parameter int CELL_W   = 16,
  parameter int CAPACITY = 20,
  localparam int QW     = $clog2(NUM_Q),
  localparam int BL     = $clog2(BATCH),
  localparam int RW     = $clog2(QDEPTH) - BL,
  localparam int ROWS   = QDEPTH / BATCH,
  localparam int BANK_D = NUM_Q * ROWS,
  localparam int AW     = QW + RW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [QW-1:0]           in_qid,
  input  logic [CELL_W-1:0]       in_data,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [QW-1:0]           out_qid,
  output logic [BATCH*CELL_W-1:0] out_data,
  output logic                    ovf
);

  logic [NUM_Q-1:0] elig;
  logic             any;
  logic [QW-1:0]    sel;
  logic [QW-1:0]    ptr;
  logic             grant;
  logic             accept, drop;
  logic [BL-1:0]    wr_bank;
  logic [RW-1:0]    wr_row, rd_row;

  assign grant = any && (!out_valid || out_ready);

  qwb_rr_arb #(.N(NUM_Q)) u_arb (
    .elig (elig),
    .ptr  (ptr),
    .any  (any),
    .sel  (sel)
  );

  qwb_occupancy #(
    .NUM_Q    (NUM_Q),
    .BATCH    (BATCH),
    .QDEPTH   (QDEPTH),
    .CAPACITY (CAPACITY)
  ) u_occ (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_qid   (in_qid),
    .grant    (grant),
    .grant_q  (sel),
    .accept   (accept),
    .drop     (drop),
    .wr_bank  (wr_bank),
    .wr_row   (wr_row),
    .rd_row   (rd_row),
    .elig     (elig)
  );

  // one bank per lane; a queue's k-th cell of a row lands in bank k
  for (genvar b = 0; b < BATCH; b++) begin : g_lane
    qwb_bank #(.W(CELL_W), .DEPTH(BANK_D)) u_bank (
      .clk   (clk),
      .we    (accept && (wr_bank == BL'(b))),
      .waddr (AW'({in_qid, wr_row})),
      .wdata (in_data),
      .re    (grant),
      .raddr (AW'({sel, rd_row})),
      .rdata (out_data[b*CELL_W +: CELL_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_qid   <= '0;
      ptr       <= '0;
      ovf       <= 1'b0;
    end else begin
      ovf <= drop;
      if (grant) begin
        out_valid <= 1'b1;
        out_qid   <= sel;
        ptr       <= QW'(qwb_pkg::wrap_add(int'(sel), 1, NUM_Q));
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_qid) && $stable(out_data));

  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |-> $past(in_valid));

endmodule

// File: tb/qwb_batch_sched_tb.sv
module qwb_batch_sched_tb;
  localparam int NQ = 4, B = 4, QD = 8, CW = 16, CAP = 20, QW = 2;

  typedef logic [CW-1:0] cell_t;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [QW-1:0] in_qid = '0;
  logic [CW-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic out_valid, ovf;
  logic [QW-1:0] out_qid;
  logic [B*CW-1:0] out_data;

  always #10 clk = ~clk;

  qwb_batch_sched #(.NUM_Q(NQ), .BATCH(B), .QDEPTH(QD), .CELL_W(CW), .CAPACITY(CAP)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_qid(in_qid), .in_data(in_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_qid(out_qid),
    .out_data(out_data), .ovf(ovf)
  );

  // behavioural reference
  cell_t mq [NQ][$];
  int m_total, m_ptr, m_qid;
  bit m_valid, m_ovf;
  logic [B*CW-1:0] m_data;

  always @(posedge clk) begin
    bit drop;
    int sel;
    sel = -1;
    if (rst) begin
      for (int q = 0; q < NQ; q++) mq[q].delete();
      m_total = 0; m_ptr = 0; m_valid = 0; m_qid = 0; m_ovf = 0;
    end else begin
      drop = in_valid && (m_total >= CAP || mq[in_qid].size() >= QD);
      m_ovf = drop;
      if (!m_valid || out_ready) begin
        for (int i = 0; i < NQ; i++)
          if (sel < 0 && mq[(m_ptr + i) % NQ].size() >= B) sel = (m_ptr + i) % NQ;
        if (sel >= 0) begin
          for (int k = 0; k < B; k++) m_data[k*CW +: CW] = mq[sel].pop_front();
          m_valid = 1; m_qid = sel; m_ptr = (sel + 1) % NQ; m_total -= B;
        end else m_valid = 0;
      end
      if (in_valid && !drop) begin
        mq[in_qid].push_back(in_data);
        m_total++;
      end
    end
  end

  int vectors = 0, fails = 0;
  logic [CW-1:0] seq = 16'h0100;
  logic p_valid = 1'b0;
  logic [QW-1:0] p_qid;
  logic [B*CW-1:0] p_data;

  task automatic chk(string tag, string what, logic [B*CW-1:0] act, logic [B*CW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R3 R4 R10", "out_valid", 64'(out_valid), 64'(m_valid));
    chk("R8 R9", "ovf", 64'(ovf), 64'(m_ovf));
    if (m_valid && out_valid) begin
      chk("R5", "out_qid", 64'(out_qid), 64'(m_qid));
      chk("R6 R2", "out_data", out_data, m_data);
    end
    if (p_valid && !out_ready) begin
      chk("R7", "held valid", 64'(out_valid), 64'(1));
      chk("R7", "held qid", 64'(out_qid), 64'(p_qid));
      chk("R7", "held data", out_data, p_data);
    end
    p_valid = out_valid; p_qid = out_qid; p_data = out_data;
  endtask

  task automatic step(bit v, int q, bit rdy);
    @(negedge clk);
    compare();
    in_valid = v;
    in_qid = QW'(q);
    if (v) begin in_data = seq; seq = seq + 16'd1; end
    out_ready = rdy;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 64'(out_valid), 64'(0));
    chk("R1", "ovf in reset", 64'(ovf), 64'(0));
    rst = 1'b0;
    // R1 R4 R6: a single batch into queue 2 with the output free
    for (int i = 0; i < B; i++) step(1, 2, 1);
    repeat (4) step(0, 0, 1);
    // R5 R7: three queues filled under stall, then released back to back (R10)
    for (int i = 0; i < B; i++) begin step(1, 3, 0); step(1, 0, 0); step(1, 1, 0); end
    repeat (4) step(0, 0, 0);
    repeat (6) step(0, 0, 1);
    // R2: continuous arrivals to queue 1 while it is being served
    for (int i = 0; i < 3*B + 2; i++) step(1, 1, 1);
    repeat (8) step(0, 0, 1);
    // R8: fill past total capacity with the output stalled
    for (int i = 0; i < 32; i++) step(1, i % NQ, 0);
    repeat (20) step(0, 0, 1);
    // R9: one queue past its depth
    for (int i = 0; i < QD + B + 3; i++) step(1, 3, 0);
    repeat (20) step(0, 0, 1);
    // mixed random traffic and back-pressure
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 6, int'($urandom % NQ), ($urandom % 10) < 7);
    repeat (40) step(0, 0, 1);
    summary();
    $finish;
  end

endmodule